// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block runs the master side of transfers on a byte-level bus abstraction. The bus side offers four operations: start with a 7-bit address and direction, send one byte and return its acknowledge, receive one byte, and stop. Each operation is one request/done handshake, and the sequencer handles at most one byte per handshake. Software drives a control register and a 16-bit length register. It pushes transmit bytes into a small shared byte buffer and pops received bytes out of it.

In counted mode the live count falls by one for each byte moved. When the count reaches zero, the sequencer does one of two things. If a stop was requested, it issues a stop. Otherwise it parks, raises access-ready and drops the master bit. In repeat mode the count is ignored: the sequencer keeps moving bytes until software asks for a stop. A missing acknowledge, on the address or on a data byte, raises a sticky flag and withdraws any stop request. The sequencer re-evaluates every cycle, so it reacts to every buffer push or pop.

Top module: `i2c_xfer_seq`

## Requirements
- R1: A control write stores the written value AND 0xCF87. Bit meanings: 15 enable, 14 byte order (stored only), 10 master, 9 transmit, 8 ten-bit address, 2 repeat mode, 1 stop request, 0 start.
- R2: A control write with enable, master and start set and the ten-bit bit clear, made while the sequencer is idle, does four things. It issues a start operation (bus_op_o 0) to slave_addr_i with bus_rd_o equal to the inverse of bit 9. The start bit reads back 0. The buffer is emptied. The live count loads from the length register.
- R3: An address that is not acknowledged sets nack_o and clears the stop bit, and no data operation follows.
- R4: Counted transmit sends buffered bytes in push order (bus_op_o 1) while the live count is non-zero, decrementing it once per byte. xrdy_o is high only while transmitting, with room in the buffer and a non-zero count (or in repeat mode).
- R5: Counted receive issues receive operations (bus_op_o 2) while the count is non-zero and fewer than 4 bytes are buffered. rrdy_o is high while in receive direction with the buffer non-empty, and bytes pop out in arrival order.
- R6: At count zero with the stop bit set, the sequencer issues one stop (bus_op_o 3), clears the stop bit, reloads the live count and drops unsent transmit bytes.
- R7: At count zero without the stop bit, ardy_o sets and the master bit clears, and no stop is issued.
- R8: Repeat mode (bit 2) leaves the live count untouched. It transmits every buffered byte, or fills the receive buffer to 4 and then waits. A stop request ends the transfer at once.
- R9: A data byte that is not acknowledged sets nack_o, clears the stop bit and ends the transfer without a stop.
- R10: Start with enable set but master clear, or with the ten-bit bit set, produces no bus operation.
- R11: With LEGACY_RESET set, a control write with enable clear resets control, length, live count, buffer and both flags.
- R12: A host pop that empties the receive buffer while the sequencer is idle, master is set and transmit is clear sets ardy_o and clears the master bit.
- R13: evt_clr_i[0] clears nack_o and evt_clr_i[1] clears ardy_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 16 | Control write data |
| cnt_we_i | input | 1 | Length register write strobe |
| cnt_wdata_i | input | CNT_W | Length write data |
| slave_addr_i | input | 7 | Target slave address |
| tx_push_i | input | 1 | Push a transmit byte |
| tx_data_i | input | 8 | Transmit byte |
| rx_pop_i | input | 1 | Pop a received byte |
| rx_data_o | output | 8 | Oldest buffered byte |
| evt_clr_i | input | 2 | Flag clear: bit 0 no-acknowledge, bit 1 access-ready |
| ctrl_o | output | 16 | Control register contents |
| live_cnt_o | output | CNT_W | Live byte count |
| xrdy_o | output | 1 | Transmit ready |
| rrdy_o | output | 1 | Receive data available |
| ardy_o | output | 1 | Access-ready flag |
| nack_o | output | 1 | No-acknowledge flag |
| bus_req_o | output | 1 | Bus operation request |
| bus_op_o | output | 2 | Operation: 0 start, 1 send, 2 receive, 3 stop |
| bus_addr_o | output | 7 | Address for start |
| bus_rd_o | output | 1 | Start direction, 1 = read |
| bus_wdata_o | output | 8 | Byte to send |
| bus_done_i | input | 1 | Operation complete |
| bus_ack_i | input | 1 | Acknowledge for start or send |
| bus_rdata_i | input | 8 | Received byte |

## Verification
The bench uses the default parameters: a 4-byte buffer, a 16-bit length and LEGACY_RESET set to 1. A buffer of 4 lets a 6-byte counted receive fill the buffer and stall. It must then resume as the host pops, which exercises both the room condition and the final-drain access-ready path. The legacy setting makes the full reset on disable reachable. The bench also covers address and data no-acknowledge, and a repeat-mode transmit longer than the buffer.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int unsigned CB_EN  = 15;
  localparam int unsigned CB_MST = 10;
  localparam int unsigned CB_TRX = 9;
  localparam int unsigned CB_XA  = 8;
  localparam int unsigned CB_RM  = 2;
  localparam int unsigned CB_STP = 1;
  localparam int unsigned CB_STT = 0;
  localparam logic [15:0] CTRL_KEEP = 16'hCF87;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_RUN, S_SEND, S_RECV, S_STOP
  } seq_st_e;
endpackage

// File: rtl/i2c_seq_fifo.sv
module i2c_seq_fifo #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [7:0]    din_i,
  input  logic          pop_i,
  output logic [7:0]    head_o,
  output logic [CW-1:0] cnt_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0; wr_q <= '0; cnt_q <= '0;
    end else if (flush_i) begin
      rd_q <= '0; wr_q <= '0; cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + CW'(1);
      else if (pop_i && !push_i) cnt_q <= cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wr_q] <= din_i;
  end

  assign head_o = mem_q[rd_q];
  assign cnt_o  = cnt_q;

  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && !pop_i && !flush_i && cnt_q == CW'(DEPTH)));
  a_r5_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pop_i && !flush_i && cnt_q == '0));
endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
  import i2c_seq_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_rst_i,
  input  logic             en_i,
  input  logic             launch_i,
  input  logic             tx_dir_i,
  input  logic             repeat_i,
  input  logic             stop_req_i,
  input  logic [CNT_W-1:0] cnt_load_i,
  input  logic [CW-1:0]    fifo_cnt_i,
  input  logic [7:0]       fifo_head_i,
  output logic             fifo_flush_o,
  output logic             fifo_pop_o,
  output logic             fifo_push_o,
  output logic             clr_stop_o,
  output logic             park_o,
  output logic             nack_evt_o,
  output logic             xrdy_o,
  output logic             idle_o,
  output logic [CNT_W-1:0] live_cnt_o,
  output logic             bus_req_o,
  output bus_op_e          bus_op_o,
  output logic [7:0]       bus_wdata_o,
  input  logic             bus_done_i,
  input  logic             bus_ack_i
);
  seq_st_e          st_q;
  logic [CNT_W-1:0] live_q;
  logic             empty, full, cnt_zero;

  assign empty    = (fifo_cnt_i == '0);
  assign full     = (fifo_cnt_i == CW'(DEPTH));
  assign cnt_zero = (live_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; live_q <= '0;
    end else if (sw_rst_i) begin
      st_q <= S_IDLE; live_q <= '0;
    end else if (!en_i && !launch_i) begin
      st_q <= S_IDLE;
    end else begin
      unique case (st_q)
        S_IDLE: if (launch_i) begin
          live_q <= cnt_load_i;
          st_q   <= S_START;
        end
        S_START: if (bus_done_i) st_q <= bus_ack_i ? S_RUN : S_IDLE;
        S_RUN: begin
          if (repeat_i) begin
            if (stop_req_i)                st_q <= S_STOP;
            else if (tx_dir_i && !empty)   st_q <= S_SEND;
            else if (!tx_dir_i && !full)   st_q <= S_RECV;
          end else if (cnt_zero) begin
            st_q <= stop_req_i ? S_STOP : S_IDLE;
          end else if (tx_dir_i && !empty) st_q <= S_SEND;
          else if (!tx_dir_i && !full)     st_q <= S_RECV;
        end
        S_SEND: if (bus_done_i) begin
          if (!repeat_i) live_q <= live_q - CNT_W'(1);
          st_q <= bus_ack_i ? S_RUN : S_IDLE;
        end
        S_RECV: if (bus_done_i) begin
          if (!repeat_i) live_q <= live_q - CNT_W'(1);
          st_q <= S_RUN;
        end
        S_STOP: if (bus_done_i) begin
          live_q <= cnt_load_i;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    fifo_flush_o = (st_q == S_IDLE && launch_i) ||
                   (st_q == S_STOP && bus_done_i && tx_dir_i);
    fifo_pop_o   = (st_q == S_SEND) && bus_done_i;
    fifo_push_o  = (st_q == S_RECV) && bus_done_i;
    nack_evt_o   = bus_done_i && !bus_ack_i && (st_q == S_START || st_q == S_SEND);
    clr_stop_o   = nack_evt_o || (st_q == S_STOP && bus_done_i);
    park_o       = en_i && (st_q == S_RUN) && !repeat_i && cnt_zero && !stop_req_i;
    xrdy_o       = tx_dir_i && (st_q == S_RUN || st_q == S_SEND) && !full &&
                   (repeat_i || !cnt_zero);
    idle_o       = (st_q == S_IDLE);
    bus_req_o    = (st_q == S_START) || (st_q == S_SEND) ||
                   (st_q == S_RECV)  || (st_q == S_STOP);
    unique case (st_q)
      S_SEND:  bus_op_o = OP_SEND;
      S_RECV:  bus_op_o = OP_RECV;
      S_STOP:  bus_op_o = OP_STOP;
      default: bus_op_o = OP_START;
    endcase
  end

  assign bus_wdata_o = fifo_head_i;
  assign live_cnt_o  = live_q;

  // one byte per handshake: a request holds until done
  a_r4_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_done_i && en_i && !sw_rst_i) |=> (bus_req_o && $stable(bus_op_o)));
  a_r4_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_SEND && bus_done_i && !repeat_i && en_i && !sw_rst_i)
      |=> (live_q == $past(live_q) - CNT_W'(1)));
  a_r6_stop_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_op_o == OP_STOP && !repeat_i) |-> cnt_zero);
  a_r8_repeat_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_RECV && bus_done_i && repeat_i && en_i && !sw_rst_i) |=> $stable(live_q));
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
  import i2c_seq_pkg::*;
#(
  parameter int unsigned DEPTH        = 4,
  parameter int unsigned CNT_W        = 16,
  parameter bit          LEGACY_RESET = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic [15:0]      ctrl_wdata_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic [6:0]       slave_addr_i,
  input  logic             tx_push_i,
  input  logic [7:0]       tx_data_i,
  input  logic             rx_pop_i,
  output logic [7:0]       rx_data_o,
  input  logic [1:0]       evt_clr_i,
  output logic [15:0]      ctrl_o,
  output logic [CNT_W-1:0] live_cnt_o,
  output logic             xrdy_o,
  output logic             rrdy_o,
  output logic             ardy_o,
  output logic             nack_o,
  output logic             bus_req_o,
  output logic [1:0]       bus_op_o,
  output logic [6:0]       bus_addr_o,
  output logic             bus_rd_o,
  output logic [7:0]       bus_wdata_o,
  input  logic             bus_done_i,
  input  logic             bus_ack_i,
  input  logic [7:0]       bus_rdata_i
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [15:0]      ctrl_q;
  logic [CNT_W-1:0] len_q;
  logic             ardy_q, nack_q;
  logic [CW-1:0]    fifo_cnt;
  logic [7:0]       fifo_head, fifo_din;
  logic             fifo_flush, fifo_push, fifo_pop, fifo_empty, fifo_full;
  logic             fsm_flush, fsm_pop, fsm_push, clr_stop, park, nack_evt, fsm_idle;
  logic             launch, sw_rst, host_push, host_pop, rx_drain, tx_dir;
  bus_op_e          op;

  assign tx_dir     = ctrl_q[CB_TRX];
  assign fifo_empty = (fifo_cnt == '0);
  assign fifo_full  = (fifo_cnt == CW'(DEPTH));

  assign launch = ctrl_we_i && ctrl_wdata_i[CB_EN] && ctrl_wdata_i[CB_MST] &&
                  !ctrl_wdata_i[CB_XA] && ctrl_wdata_i[CB_STT] && fsm_idle;
  assign sw_rst = LEGACY_RESET && ctrl_we_i && !ctrl_wdata_i[CB_EN];

  assign host_push = tx_push_i && tx_dir && !fifo_full;
  assign host_pop  = rx_pop_i && !tx_dir && !fifo_empty;
  assign rx_drain  = host_pop && fifo_cnt == CW'(1) && fsm_idle &&
                     ctrl_q[CB_MST] && !ctrl_q[CB_TRX];

  assign fifo_flush = fsm_flush || sw_rst;
  assign fifo_push  = tx_dir ? host_push : fsm_push;
  assign fifo_pop   = tx_dir ? fsm_pop : host_pop;
  assign fifo_din   = tx_dir ? tx_data_i : bus_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0; len_q <= '0; ardy_q <= 1'b0; nack_q <= 1'b0;
    end else if (sw_rst) begin
      ctrl_q <= '0; len_q <= '0; ardy_q <= 1'b0; nack_q <= 1'b0;
    end else begin
      if (ctrl_we_i) begin
        ctrl_q <= (ctrl_wdata_i & CTRL_KEEP) & ~{15'd0, launch};
      end else begin
        if (clr_stop)         ctrl_q[CB_STP] <= 1'b0;
        if (park || rx_drain) ctrl_q[CB_MST] <= 1'b0;
      end
      if (cnt_we_i) len_q <= cnt_wdata_i;
      if (park || rx_drain) ardy_q <= 1'b1;
      else if (evt_clr_i[1]) ardy_q <= 1'b0;
      if (nack_evt) nack_q <= 1'b1;
      else if (evt_clr_i[0]) nack_q <= 1'b0;
    end
  end

  i2c_seq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .flush_i(fifo_flush), .push_i(fifo_push), .din_i(fifo_din),
    .pop_i(fifo_pop), .head_o(fifo_head), .cnt_o(fifo_cnt)
  );

  i2c_seq_fsm #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fsm (
    .clk_i, .rst_ni,
    .sw_rst_i(sw_rst), .en_i(ctrl_q[CB_EN]), .launch_i(launch),
    .tx_dir_i(tx_dir), .repeat_i(ctrl_q[CB_RM]), .stop_req_i(ctrl_q[CB_STP]),
    .cnt_load_i(len_q), .fifo_cnt_i(fifo_cnt), .fifo_head_i(fifo_head),
    .fifo_flush_o(fsm_flush), .fifo_pop_o(fsm_pop), .fifo_push_o(fsm_push),
    .clr_stop_o(clr_stop), .park_o(park), .nack_evt_o(nack_evt),
    .xrdy_o(xrdy_o), .idle_o(fsm_idle), .live_cnt_o(live_cnt_o),
    .bus_req_o(bus_req_o), .bus_op_o(op), .bus_wdata_o(bus_wdata_o),
    .bus_done_i(bus_done_i), .bus_ack_i(bus_ack_i)
  );

  assign bus_op_o   = op;
  assign bus_addr_o = slave_addr_i;
  assign bus_rd_o   = !tx_dir;
  assign rx_data_o  = fifo_head;
  assign rrdy_o     = !tx_dir && !fifo_empty;
  assign ardy_o     = ardy_q;
  assign nack_o     = nack_q;
  assign ctrl_o     = ctrl_q;

  a_r3_nack_drops_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(nack_q) && !$past(ctrl_we_i)) |-> !ctrl_q[CB_STP]);
  a_r2_start_self_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && op == OP_START) |-> !ctrl_q[CB_STT]);
  a_r10_no_slave_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q[CB_MST] && fsm_idle && !launch) |=> !bus_req_o);
endmodule

// File: tb/i2c_xfer_seq_test.sv
module i2c_xfer_seq_test;
  localparam logic [15:0] EN = 16'h8000, MST = 16'h0400, TRX = 16'h0200,
                          XA = 16'h0100, RM = 16'h0004, STP = 16'h0002, STT = 16'h0001;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        ctrl_we = 0, cnt_we = 0, tx_push = 0, rx_pop = 0;
  logic [15:0] ctrl_wd = 0, cnt_wd = 0;
  logic [7:0]  tx_data = 0;
  logic [1:0]  evt_clr = 0;
  logic [7:0]  rx_data, bus_wdata, bus_rdata;
  logic [15:0] ctrl, live;
  logic        xrdy, rrdy, ardy, nack, bus_req, bus_rd, bus_done, bus_ack;
  logic [1:0]  bus_op;
  logic [6:0]  bus_addr;

  i2c_xfer_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd),
    .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wd), .slave_addr_i(7'h2A),
    .tx_push_i(tx_push), .tx_data_i(tx_data), .rx_pop_i(rx_pop), .rx_data_o(rx_data),
    .evt_clr_i(evt_clr), .ctrl_o(ctrl), .live_cnt_o(live), .xrdy_o(xrdy), .rrdy_o(rrdy),
    .ardy_o(ardy), .nack_o(nack), .bus_req_o(bus_req), .bus_op_o(bus_op),
    .bus_addr_o(bus_addr), .bus_rd_o(bus_rd), .bus_wdata_o(bus_wdata),
    .bus_done_i(bus_done), .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata)
  );

  // bus model
  logic       start_ack = 1;
  int         nack_idx = -1;
  int         n_start, n_send, n_recv, n_stop, lat;
  logic [7:0] sent [16];
  logic [6:0] last_addr;
  logic       last_rd;

  always @(posedge clk) begin
    bus_done <= 1'b0;
    if (bus_req && !bus_done) begin
      if (lat == 2) begin
        lat <= 0;
        bus_done <= 1'b1;
        bus_ack <= 1'b1;
        case (bus_op)
          2'd0: begin n_start <= n_start + 1; last_addr <= bus_addr; last_rd <= bus_rd;
                      bus_ack <= start_ack; end
          2'd1: begin sent[n_send[3:0]] <= bus_wdata; n_send <= n_send + 1;
                      bus_ack <= (n_send != nack_idx); end
          2'd2: begin bus_rdata <= 8'h50 + 8'(n_recv); n_recv <= n_recv + 1; end
          default: n_stop <= n_stop + 1;
        endcase
      end else lat <= lat + 1;
    end
  end

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_bus;
    n_start = 0; n_send = 0; n_recv = 0; n_stop = 0;
    nack_idx = -1; start_ack = 1;
  endtask

  task automatic wr_ctrl(input logic [15:0] v);
    @(negedge clk); ctrl_we = 1; ctrl_wd = v;
    @(negedge clk); ctrl_we = 0;
  endtask

  task automatic wr_cnt(input logic [15:0] v);
    @(negedge clk); cnt_we = 1; cnt_wd = v;
    @(negedge clk); cnt_we = 0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); tx_push = 1; tx_data = b;
    @(negedge clk); tx_push = 0;
  endtask

  task automatic pop(output logic [7:0] b);
    @(negedge clk); b = rx_data; rx_pop = 1;
    @(negedge clk); rx_pop = 0;
  endtask

  task automatic clr_evt;
    @(negedge clk); evt_clr = 2'b11;
    @(negedge clk); evt_clr = 2'b00;
  endtask

  task automatic t_reset;
    check("R11 reset ctrl", ctrl, 0);
    check("R11 reset live", live, 0);
    check("R13 reset flags", {ardy, nack}, 0);
    check("R4 reset req", bus_req, 0);
  endtask

  task automatic t_mask;
    clr_bus();
    wr_ctrl(16'hFFFE);
    check("R1 mask", ctrl, 16'hCF86);
    run(10);
    check("R10 xa no start", n_start, 0);
    wr_ctrl(16'h0000);
    check("R11 disable clears", ctrl, 0);
  endtask

  task automatic t_tx_stop;
    clr_bus();
    wr_cnt(3);
    wr_ctrl(EN | MST | TRX | STP | STT);
    check("R2 start cleared", ctrl, EN | MST | TRX | STP);
    check("R2 live load", live, 3);
    run(8);
    check("R2 start issued", n_start, 1);
    check("R2 addr", last_addr, 7'h2A);
    check("R2 write dir", last_rd, 0);
    check("R4 xrdy waiting", xrdy, 1);
    push(8'hA1); push(8'hB2); push(8'hC3);
    run(60);
    check("R4 sent count", n_send, 3);
    check("R4 byte0", sent[0], 8'hA1);
    check("R4 byte1", sent[1], 8'hB2);
    check("R4 byte2", sent[2], 8'hC3);
    check("R6 one stop", n_stop, 1);
    check("R6 stop cleared", ctrl, EN | MST | TRX);
    check("R6 reload", live, 3);
    check("R6 no ardy", ardy, 0);
    check("R4 xrdy idle", xrdy, 0);
  endtask

  task automatic t_tx_park;
    clr_bus();
    wr_cnt(2);
    wr_ctrl(EN | MST | TRX | STT);
    push(8'h11); push(8'h22);
    run(40);
    check("R7 sent", n_send, 2);
    check("R7 ardy", ardy, 1);
    check("R7 master cleared", ctrl, EN | TRX);
    check("R7 no stop", n_stop, 0);
    check("R7 live zero", live, 0);
    clr_evt();
    check("R13 ardy cleared", ardy, 0);
  endtask

  task automatic t_addr_nack;
    clr_bus();
    start_ack = 0;
    wr_ctrl(EN | MST | TRX | STP | STT);
    push(8'h33);
    run(20);
    check("R3 nack", nack, 1);
    check("R3 stop cleared", ctrl, EN | MST | TRX);
    check("R3 no send", n_send, 0);
    check("R3 bus quiet", bus_req, 0);
    clr_evt();
    check("R13 nack cleared", nack, 0);
  endtask

  task automatic t_data_nack;
    clr_bus();
    nack_idx = 1;
    wr_cnt(3);
    wr_ctrl(EN | MST | TRX | STP | STT);
    push(8'h44); push(8'h55); push(8'h66);
    run(40);
    check("R9 nack", nack, 1);
    check("R9 sends", n_send, 2);
    check("R9 no stop", n_stop, 0);
    check("R9 stop cleared", ctrl, EN | MST | TRX);
    check("R9 live", live, 1);
    clr_evt();
  endtask

  task automatic t_rx_counted;
    logic [7:0] b;
    clr_bus();
    wr_cnt(6);
    wr_ctrl(EN | MST | STP | STT);
    run(40);
    check("R2 read dir", last_rd, 1);
    check("R5 fill stalls", n_recv, 4);
    check("R5 rrdy", rrdy, 1);
    check("R5 live", live, 2);
    for (int i = 0; i < 6; i++) begin
      if (i == 5) check("R12 ardy before drain", ardy, 0);
      pop(b);
      check("R5 rx byte", b, 8'h50 + 8'(i));
      run(20);
    end
    check("R5 total recv", n_recv, 6);
    check("R6 rx stop", n_stop, 1);
    check("R5 rrdy empty", rrdy, 0);
    check("R12 ardy", ardy, 1);
    check("R12 master cleared", ctrl, EN);
    check("R6 rx reload", live, 6);
    clr_evt();
  endtask

  task automatic t_repeat_tx;
    clr_bus();
    wr_cnt(0);
    wr_ctrl(EN | MST | TRX | RM | STT);
    push(8'h01); push(8'h02); push(8'h03); push(8'h04);
    run(40);
    push(8'h05);
    run(30);
    check("R8 all sent", n_send, 5);
    check("R8 last byte", sent[4], 8'h05);
    check("R8 live untouched", live, 0);
    check("R8 xrdy", xrdy, 1);
    check("R8 no stop yet", n_stop, 0);
    wr_ctrl(EN | MST | TRX | RM | STP);
    run(20);
    check("R8 stop", n_stop, 1);
    check("R8 stop bit cleared", ctrl, EN | MST | TRX | RM);
  endtask

  task automatic t_repeat_rx;
    clr_bus();
    wr_cnt(2);
    wr_ctrl(EN | MST | RM | STT);
    run(60);
    check("R8 rx fill", n_recv, 4);
    check("R8 rx live", live, 2);
    run(40);
    check("R8 rx held", n_recv, 4);
    wr_ctrl(EN | MST | RM | STP);
    run(20);
    check("R8 rx stop", n_stop, 1);
  endtask

  task automatic t_no_xfer;
    clr_bus();
    wr_ctrl(EN | TRX | STT);
    run(20);
    check("R10 no master", n_start, 0);
    wr_ctrl(EN | MST | XA | STT);
    run(20);
    check("R10 ten bit", n_start, 0);
  endtask

  task automatic t_legacy;
    clr_bus();
    start_ack = 0;
    wr_cnt(5);
    wr_ctrl(EN | MST | TRX | STT);
    run(20);
    check("R11 pre live", live, 5);
    check("R11 pre nack", nack, 1);
    wr_ctrl(16'h0000);
    check("R11 live cleared", live, 0);
    check("R11 nack cleared", nack, 0);
    check("R11 ctrl cleared", ctrl, 0);
    start_ack = 1;
    wr_ctrl(EN | MST | TRX | STT);
    check("R11 length cleared", live, 0);
  endtask

  initial begin
    clr_bus();
    lat = 0; bus_ack = 0; bus_rdata = 0;
    run(3);
    rst_n = 1;
    run(2);
    t_reset();
    t_mask();
    t_tx_stop();
    t_tx_park();
    t_addr_nack();
    t_data_nack();
    t_rx_counted();
    t_repeat_tx();
    t_repeat_rx();
    t_no_xfer();
    t_legacy();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule